// File: doc/BRIEF.md
# SAR Converter Serial Slave Front End

This block is the device-side digital serial port of an eight-input, 12-bit successive-approximation converter. A host drives an active-low chip select, a serial clock and a data line. The block finds the start bit and reads a four-bit command: a mode bit followed by a three-bit channel field. It then raises a sample window and returns the conversion result on a tri-stated data output. The analog path is not modelled. The result for each input comes from two parallel buses, one for single-ended readings and one for pseudo-differential readings, and the surrounding logic or a testbench drives them.

The serial pins are sampled by a faster system clock `clk`. The block detects serial clock edges internally, so each serial clock phase must last at least three `clk` periods. Every registered output responds two `clk` cycles after the serial pin change that caused it: one cycle to register the pin and one to update the state. After the sample window the output carries a null bit, then the result MSB first, then the same result LSB first, and then zeros for as long as chip select stays low.

Top module: `sar_serial_slave`

## Requirements
- R1: While reset is asserted and in the first cycles after reset, `dout_oe`, `sample_win` and `dout` are all 0.
- R2: If chip select is low when reset is released, no start bit is accepted, no sample window opens and `dout_oe` stays 0 until chip select has gone high and then low again.
- R3: With chip select low, serial clock rising edges that see `din` low before the start bit are ignored. The start bit is the first rising edge that sees `din` high.
- R4: The four rising edges after the start bit capture, in order, the mode bit, then channel bits 2, 1 and 0. Mode 1 returns `se_data[ch*12 +: 12]`. Mode 0 returns `diff_data[ch*12 +: 12]`, where ch = pair*2 + polarity. Later `din` values have no effect.
- R5: `sample_win` rises on the fourth rising edge after the start bit. It stays high through the next falling edge and the next rising edge, and falls on the falling edge after those, so the window lasts 1.5 serial clock periods. It is never high together with `dout_oe`.
- R6: On the falling edge that closes the sample window, `dout_oe` rises and `dout` drives a 0 null bit. The next twelve falling edges each present one result bit, from B11 down to B0. `dout` changes only after falling edges.
- R7: If falling edges continue with chip select low after B0, `dout` presents B1 through B11 in that order, and then 0 on every later falling edge.
- R8: Chip select high at any point aborts the transfer. `dout_oe` and `sample_win` are 0 two cycles later, and the next transfer begins with a fresh start-bit search.
- R9: The result is latched when the sample window closes. Later changes on `se_data` or `diff_data` do not alter the bits being shifted.
- R10: Whenever `dout_oe` is 0, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command input |
| se_data | input | NUM_CH*RES_W | Single-ended results, channel ch at bits ch*RES_W upward |
| diff_data | input | NUM_CH*RES_W | Pseudo-differential results, indexed by pair*2+polarity |
| dout | output | 1 | Serial result output, valid while dout_oe is 1 |
| dout_oe | output | 1 | Drive enable for dout; 0 means high impedance |
| sample_win | output | 1 | High during the sample window |

## Verification
Almost any fault in the command capture or the bit counter shows up at `dout` within one serial clock period of the window closing. A wrong captured channel or mode yields a wrong word from the first result bit. A count that is off by one shifts the whole MSB-first, LSB-first and zero-tail pattern by a bit position. A stale arm or abort state shows up as an opened sample window or a driven output where the host expects high impedance, two system clocks after the offending pin change. The bench compares every bit against a reference built from the channel buses and the command it sent, and it changes the buses after the latch point.

// File: rtl/sar_ss_pkg.sv
package sar_ss_pkg;

    typedef enum logic [2:0] {
        ST_ARM    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_CMD    = 3'd2,
        ST_SAMPLE = 3'd3,
        ST_SHIFT  = 3'd4
    } sif_state_e;

endpackage

// File: rtl/sar_ss_sync.sv
module sar_ss_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic cs_hi,
    output logic din_s,
    output logic rise,
    output logic fall
);
    logic cs_q, sclk_q, sclk_p, din_q;

    // cs resets to "low" so an idle-high pin must be observed before arming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b0;
            sclk_q <= 1'b0;
            sclk_p <= 1'b0;
            din_q  <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
            sclk_p <= sclk_q;
            din_q  <= din;
        end
    end

    assign cs_hi = cs_q;
    assign din_s = din_q;
    assign rise  = sclk_q & ~sclk_p;
    assign fall  = ~sclk_q & sclk_p;
endmodule

// File: rtl/sar_ss_mux.sv
module sar_ss_mux #(
    parameter int RES_W  = 12,
    parameter int NUM_CH = 8,
    parameter int SEL_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH*RES_W-1:0] se_data,
    input  logic [NUM_CH*RES_W-1:0] diff_data,
    input  logic                    single,
    input  logic [SEL_W-1:0]        sel,
    output logic [RES_W-1:0]        word
);
    logic [RES_W-1:0] se_arr   [NUM_CH];
    logic [RES_W-1:0] diff_arr [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign se_arr[g]   = se_data[g*RES_W +: RES_W];
        assign diff_arr[g] = diff_data[g*RES_W +: RES_W];
    end

    assign word = single ? se_arr[sel] : diff_arr[sel];
endmodule

// File: rtl/sar_ss_bitsel.sv
module sar_ss_bitsel #(
    parameter int RES_W = 12,
    parameter int CNT_W = $clog2(2*RES_W+1)
) (
    input  logic [RES_W-1:0] word,
    input  logic [CNT_W-1:0] idx,
    output logic             bit_o
);
    // idx 0: null, 1..RES_W: MSB first, RES_W+1..2*RES_W-1: LSB-first repeat, else 0
    always_comb begin
        bit_o = 1'b0;
        for (int b = 0; b < RES_W; b++) begin
            if (int'(idx) == RES_W - b)
                bit_o = word[b];
            if (b > 0 && int'(idx) == RES_W + b)
                bit_o = word[b];
        end
    end
endmodule

// File: rtl/sar_serial_slave.sv
module sar_serial_slave
    import sar_ss_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int NUM_CH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    sclk,
    input  logic                    din,
    input  logic [NUM_CH*RES_W-1:0] se_data,
    input  logic [NUM_CH*RES_W-1:0] diff_data,
    output logic                    dout,
    output logic                    dout_oe,
    output logic                    sample_win
);
    localparam int SEL_W = $clog2(NUM_CH);
    localparam int CMD_W = SEL_W + 1;
    localparam int BIT_W = (CMD_W > 1) ? $clog2(CMD_W) : 1;
    localparam int CNT_W = $clog2(2*RES_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2*RES_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CMD_W - 1);

    typedef struct packed {
        sif_state_e       state;
        logic [CMD_W-1:0] cmd;
        logic [BIT_W-1:0] bit_cnt;
        logic             half;
        logic [CNT_W-1:0] shift_cnt;
        logic [RES_W-1:0] word;
        logic             dout;
        logic             oe;
        logic             samp;
    } sif_regs_t;

    sif_regs_t q, d;

    logic cs_hi, din_s, rise, fall;
    logic [RES_W-1:0] sel_word;
    logic [CNT_W-1:0] cnt_nxt;
    logic             nxt_bit;

    sar_ss_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .din   (din),
        .cs_hi (cs_hi),
        .din_s (din_s),
        .rise  (rise),
        .fall  (fall)
    );

    sar_ss_mux #(.RES_W(RES_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_mux (
        .se_data   (se_data),
        .diff_data (diff_data),
        .single    (q.cmd[CMD_W-1]),
        .sel       (q.cmd[SEL_W-1:0]),
        .word      (sel_word)
    );

    assign cnt_nxt = (q.shift_cnt == CNT_LAST) ? q.shift_cnt : q.shift_cnt + 1'b1;

    sar_ss_bitsel #(.RES_W(RES_W), .CNT_W(CNT_W)) u_bitsel (
        .word  (q.word),
        .idx   (cnt_nxt),
        .bit_o (nxt_bit)
    );

    always_comb begin
        d = q;
        if (cs_hi) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
            d.dout  = 1'b0;
            d.samp  = 1'b0;
        end else begin
            unique case (q.state)
                ST_ARM: ;
                ST_IDLE: begin
                    if (rise && din_s) begin
                        d.state   = ST_CMD;
                        d.bit_cnt = '0;
                    end
                end
                ST_CMD: begin
                    if (rise) begin
                        d.cmd     = {q.cmd[CMD_W-2:0], din_s};
                        d.bit_cnt = q.bit_cnt + 1'b1;
                        if (q.bit_cnt == BIT_LAST) begin
                            d.state = ST_SAMPLE;
                            d.samp  = 1'b1;
                            d.half  = 1'b0;
                        end
                    end
                end
                ST_SAMPLE: begin
                    if (fall) begin
                        if (!q.half) begin
                            d.half = 1'b1;
                        end else begin
                            d.state     = ST_SHIFT;
                            d.word      = sel_word;
                            d.shift_cnt = '0;
                            d.samp      = 1'b0;
                            d.oe        = 1'b1;
                            d.dout      = 1'b0;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (fall) begin
                        d.shift_cnt = cnt_nxt;
                        d.dout      = nxt_bit;
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state     <= ST_ARM;
            q.cmd       <= '0;
            q.bit_cnt   <= '0;
            q.half      <= 1'b0;
            q.shift_cnt <= '0;
            q.word      <= '0;
            q.dout      <= 1'b0;
            q.oe        <= 1'b0;
            q.samp      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign dout       = q.dout;
    assign dout_oe    = q.oe;
    assign sample_win = q.samp;

    AST_ARM_STAYS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_ARM) |=> (q.state == ST_ARM || q.state == ST_IDLE)); // R2
    AST_WIN_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(sample_win)); // R5
    AST_WIN_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_win && dout_oe)); // R5
    AST_NULL_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> !dout); // R6
    AST_DOUT_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && $past(dout_oe) && !$past(fall)) |-> $stable(dout)); // R6
    AST_CS_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> (!dout_oe && !sample_win)); // R8
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SHIFT && $past(q.state == ST_SHIFT)) |-> $stable(q.word)); // R9
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout); // R10
endmodule

// File: tb/sar_serial_slave_tb.sv
module sar_serial_slave_tb_top;
    localparam int RES_W  = 12;
    localparam int NUM_CH = 8;
    localparam int H      = 4;

    logic clk = 1'b0;
    logic rst_n, cs_n, sclk, din;
    logic [NUM_CH*RES_W-1:0] se_data, diff_data;
    logic dout, dout_oe, sample_win;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sar_serial_slave #(.RES_W(RES_W), .NUM_CH(NUM_CH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .din        (din),
        .se_data    (se_data),
        .diff_data  (diff_data),
        .dout       (dout),
        .dout_oe    (dout_oe),
        .sample_win (sample_win)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input logic [RES_W-1:0] w, input int k);
        if (k >= 1 && k <= RES_W) return w[RES_W-k];
        if (k > RES_W && k < 2*RES_W) return w[k-RES_W];
        return 1'b0;
    endfunction

    task automatic scramble_data();
        for (int i = 0; i < NUM_CH; i++) begin
            se_data[i*RES_W +: RES_W]   = RES_W'($urandom);
            diff_data[i*RES_W +: RES_W] = RES_W'($urandom);
        end
    endtask

    task automatic xfer(input int L, input bit mode, input bit [2:0] ch, input int ncyc,
                        input int abort_at, input bit scramble, input bit dead);
        logic [RES_W-1:0] w;
        w = mode ? se_data[ch*RES_W +: RES_W] : diff_data[ch*RES_W +: RES_W];
        cs_n = 1'b0;
        din  = 1'b0;
        wait_clk(H);
        for (int j = 0; j < ncyc; j++) begin
            if (j == abort_at) begin
                cs_n = 1'b1;
                wait_clk(3);
                chk("R8 dout_oe after abort", int'(dout_oe), 0);
                chk("R8 sample_win after abort", int'(sample_win), 0);
                chk("R10 dout after abort", int'(dout), 0);
                wait_clk(H);
                return;
            end
            if (j < L)       din = 1'b0;
            else if (j == L) din = 1'b1;
            else if (j == L + 1) din = mode;
            else if (j <= L + 4) din = ch[L+4-j];
            else din = 1'($urandom);
            sclk = 1'b1;
            wait_clk(H);
            chk("R5 sample_win in high phase", int'(sample_win),
                int'(!dead && (j == L + 4 || j == L + 5)));
            chk("R6 dout_oe in high phase", int'(dout_oe), int'(!dead && j > L + 5));
            sclk = 1'b0;
            wait_clk(H);
            if (dead) begin
                chk("R2 dout_oe while unarmed", int'(dout_oe), 0);
                chk("R2 sample_win while unarmed", int'(sample_win), 0);
            end else if (j == L + 4) begin
                chk("R5 window held over half period", int'(sample_win), 1);
                chk("R5 no drive during window", int'(dout_oe), 0);
            end else if (j >= L + 5) begin
                int k;
                k = j - L - 5;
                chk("R6 dout_oe during output", int'(dout_oe), 1);
                chk("R5 window closed", int'(sample_win), 0);
                if (k == 0)          chk("R6 null bit", int'(dout), 0);
                else if (k <= RES_W) chk("R4/R6 MSB-first bit", int'(dout), int'(exp_bit(w, k)));
                else                 chk("R7 LSB-first repeat or zero tail", int'(dout), int'(exp_bit(w, k)));
            end else begin
                chk("R3 no drive before command done", int'(dout_oe), 0);
                chk("R3 no window before command done", int'(sample_win), 0);
                chk("R10 dout quiet", int'(dout), 0);
            end
            if (scramble && j == L + 6) scramble_data(); // R9
        end
        cs_n = 1'b1;
        din  = 1'b0;
        wait_clk(H);
        chk("R8 dout_oe after CS high", int'(dout_oe), 0);
        chk("R10 dout after CS high", int'(dout), 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5A3C_0917));
        rst_n = 1'b0;
        cs_n  = 1'b0;
        sclk  = 1'b0;
        din   = 1'b0;
        scramble_data();
        wait_clk(5);
        chk("R1 dout_oe in reset", int'(dout_oe), 0);
        chk("R1 sample_win in reset", int'(sample_win), 0);
        rst_n = 1'b1;
        wait_clk(2);
        chk("R1 dout_oe after reset", int'(dout_oe), 0);
        chk("R1 dout after reset", int'(dout), 0);
        chk("R1 sample_win after reset", int'(sample_win), 0);

        // R2: CS was low through reset, a start bit must be refused
        xfer(2, 1'b1, 3'd5, 24, -1, 1'b0, 1'b1);

        // Directed corners: no leading zeros, max leading zeros, extreme words
        se_data[0 +: RES_W] = 12'hFFF;
        xfer(0, 1'b1, 3'd0, 36, -1, 1'b0, 1'b0);
        diff_data[7*RES_W +: RES_W] = 12'h801;
        xfer(7, 1'b0, 3'd7, 40, -1, 1'b0, 1'b0);
        se_data[3*RES_W +: RES_W] = 12'hA5C;
        xfer(1, 1'b1, 3'd3, 34, -1, 1'b1, 1'b0); // R9

        // R8: abort during command, during window, during shift, then recover
        xfer(0, 1'b1, 3'd2, 30, 2, 1'b0, 1'b0);
        xfer(3, 1'b0, 3'd4, 30, 8, 1'b0, 1'b0);
        xfer(1, 1'b1, 3'd6, 30, 12, 1'b0, 1'b0);
        xfer(2, 1'b1, 3'd6, 30, -1, 1'b0, 1'b0);

        for (int t = 0; t < 100; t++) begin
            int L, n;
            L = int'($urandom % 8);
            n = L + 5 + 10 + int'($urandom % 26);
            scramble_data();
            xfer(L, 1'($urandom), 3'($urandom), n, -1, 1'($urandom), 1'b0);
        end

        finish_run();
    end
endmodule